// File: doc/BRIEF.md
# Small Multicycle Register Processor

This block is a compact processor core with sixteen 8-bit general registers. It runs a fixed set of seven two-byte instructions: direct and register-indirect memory moves, immediate loads, add, subtract and a zero-test relative branch. Program and data live in separate memories. An instruction fetch and a data access therefore never compete for one port. The core reads program words through a dedicated read-only port and reaches data through a single read/write port.

Every instruction takes the same five controller steps, in this order: fetch, decode (register read), execute, memory and write-back. The program counter and the register file change only in the write-back step. A data write happens only in the memory step. Any data address can be used as a memory-mapped handshake location, because the data port shows every store the same way. Two debug outputs are provided: the current program counter and the register-file write strobe. A bench can follow progress with them without looking inside the core.

In the instruction word, bits 15:12 hold the opcode, bits 11:8 name register Rn, and bits 7:0 hold an address, an immediate, an offset or Rm.

Top module: `smcpu_core`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the core clears the program counter and all 16 registers to zero. On the next cycle `dbg_pc` is 0 and both `dmem_we` and `dbg_rf_we` are low.
- R2: Each instruction occupies exactly five clock cycles. `dbg_pc` changes only at the edge that ends the fifth cycle. After reset is released, `dbg_pc` is still 0 after four edges and becomes the next address after the fifth edge.
- R3: Opcode 0x0 (load direct) writes data memory at address bits 7:0 into Rn.
- R4: Opcode 0x1 (store direct) raises `dmem_we` for one cycle with `dmem_addr` equal to bits 7:0 and `dmem_wdata` equal to Rn. No register is written.
- R5: Opcode 0x2 (store indirect) writes register Rm into data memory at the address held in Rn.
- R6: Opcode 0x3 (load immediate) writes bits 7:0 into Rn.
- R7: Opcode 0x4 sets Rn to Rn + Rm, and opcode 0x5 sets Rn to Rn - Rm. Both wrap modulo 256.
- R8: Opcode 0x6 sets the PC to (own address + sign-extended bits 7:0) when Rn is zero. Otherwise it sets the PC to the own address + 1. Backward offsets such as 0xFD step back three.
- R9: Opcodes 0x7 through 0xF write no register and no data memory, and the PC advances by one.
- R10: `dmem_we` is high only in the fourth cycle of an instruction, and `dbg_rf_we` is high only in the fifth. Each of them pulses at most once per instruction.
- R11: Rm is taken from bits 7:4 of the instruction word. Bits 3:0 do not affect which register is used as Rm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | PC_W | Program memory address (one instruction per location) |
| prog_data | input | 16 | Instruction word at `prog_addr`, valid in the same cycle |
| dmem_addr | output | DATA_W | Data memory address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | DATA_W | Data memory write value |
| dmem_rdata | input | DATA_W | Data memory read value at `dmem_addr`, valid in the same cycle |
| dbg_pc | output | PC_W | Current program counter |
| dbg_rf_we | output | 1 | Register-file write strobe |

## Verification
The properties assume that both memories answer combinationally within the cycle the address is presented. They also assume that reset is held for at least one edge before the core runs. The phase rules in R2 and R10 are checked against a five-step counter that the checker keeps itself; this counter is restarted only by reset. The bench meets these assumptions by modelling both memories as arrays read by continuous assignment. It preloads data memory only while reset is held, so no bench write ever coincides with a store from the core.

// File: rtl/smcpu_pkg.sv
package smcpu_pkg;

   localparam int INSTR_W = 16;
   localparam int OPC_W   = 4;
   localparam int FIELD_W = 8;

   typedef enum logic [2:0] {
      PH_FETCH  = 3'd0,
      PH_DECODE = 3'd1,
      PH_EXEC   = 3'd2,
      PH_MEM    = 3'd3,
      PH_WB     = 3'd4
   } phase_e;

   typedef enum logic [OPC_W-1:0] {
      OP_LOAD      = 4'h0,
      OP_STORE     = 4'h1,
      OP_STORE_IND = 4'h2,
      OP_LOAD_IMM  = 4'h3,
      OP_ADD       = 4'h4,
      OP_SUB       = 4'h5,
      OP_BR_ZERO   = 4'h6
   } opcode_e;

   typedef struct packed {
      logic rf_wr;     // writes Rn in write-back
      logic mem_wr;    // drives a data write in the memory step
      logic mem_rd;    // captures read data in the memory step
      logic indirect;  // address from Rn, data from Rm
      logic branch;    // zero-test relative branch
      logic imm;       // result is the second byte
      logic sub;       // ALU subtracts
   } decode_t;

   function automatic decode_t decode_op(input logic [OPC_W-1:0] opc);
      decode_t d;
      d = '0;
      case (opc)
         OP_LOAD:      begin d.rf_wr = 1'b1; d.mem_rd = 1'b1; end
         OP_STORE:     d.mem_wr = 1'b1;
         OP_STORE_IND: begin d.mem_wr = 1'b1; d.indirect = 1'b1; end
         OP_LOAD_IMM:  begin d.rf_wr = 1'b1; d.imm = 1'b1; end
         OP_ADD:       d.rf_wr = 1'b1;
         OP_SUB:       begin d.rf_wr = 1'b1; d.sub = 1'b1; end
         OP_BR_ZERO:   d.branch = 1'b1;
         default:      d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/smcpu_regfile.sv
module smcpu_regfile #(
   parameter int DATA_W  = 8,
   parameter int REG_CNT = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       we,
   input  logic [$clog2(REG_CNT)-1:0] waddr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [$clog2(REG_CNT)-1:0] raddr_a,
   output logic [DATA_W-1:0]          rdata_a,
   input  logic [$clog2(REG_CNT)-1:0] raddr_b,
   output logic [DATA_W-1:0]          rdata_b
);

   localparam int IDX_W = $clog2(REG_CNT);

   logic [DATA_W-1:0] cells [REG_CNT];

   generate
      for (genvar g = 0; g < REG_CNT; g++) begin : g_cell
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we && (waddr == IDX_W'(g)))
               q <= wdata;
         end
         assign cells[g] = q;
      end
   endgenerate

   assign rdata_a = cells[raddr_a];
   assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/smcpu_alu.sv
module smcpu_alu #(
   parameter int DATA_W      = 8,
   parameter bit SUB_VIA_ADD = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] y
);

   generate
      if (SUB_VIA_ADD) begin : g_shared_adder
         logic [DATA_W-1:0] b_adj;
         assign b_adj = b ^ {DATA_W{sub}};
         assign y     = a + b_adj + DATA_W'(sub);
      end else begin : g_split_paths
         assign y = sub ? (a - b) : (a + b);
      end
   endgenerate

endmodule

// File: rtl/smcpu_ctrl.sv
module smcpu_ctrl
   import smcpu_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opc,
   output phase_e           phase,
   output decode_t          dec,
   output logic             rf_we,
   output logic             mem_we,
   output logic             mem_cap
);

   phase_e phase_q;

   always_ff @(posedge clk) begin
      if (rst)
         phase_q <= PH_FETCH;
      else begin
         case (phase_q)
            PH_FETCH:  phase_q <= PH_DECODE;
            PH_DECODE: phase_q <= PH_EXEC;
            PH_EXEC:   phase_q <= PH_MEM;
            PH_MEM:    phase_q <= PH_WB;
            default:   phase_q <= PH_FETCH;
         endcase
      end
   end

   assign phase   = phase_q;
   assign dec     = decode_op(opc);
   assign rf_we   = (phase_q == PH_WB)  && dec.rf_wr;
   assign mem_we  = (phase_q == PH_MEM) && dec.mem_wr;
   assign mem_cap = (phase_q == PH_MEM) && dec.mem_rd;

endmodule

// File: rtl/smcpu_core.sv
module smcpu_core
   import smcpu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PC_W        = 8,
   parameter int REG_CNT     = 16,
   parameter bit SUB_VIA_ADD = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   output logic [PC_W-1:0]     prog_addr,
   input  logic [15:0]         prog_data,
   output logic [DATA_W-1:0]   dmem_addr,
   output logic                dmem_we,
   output logic [DATA_W-1:0]   dmem_wdata,
   input  logic [DATA_W-1:0]   dmem_rdata,
   output logic [PC_W-1:0]     dbg_pc,
   output logic                dbg_rf_we
);

   localparam int IDX_W = $clog2(REG_CNT);

   generate
      if (DATA_W < FIELD_W) begin : g_bad_data_w
         $error("smcpu_core: DATA_W must be at least 8");
      end
      if (PC_W < FIELD_W) begin : g_bad_pc_w
         $error("smcpu_core: PC_W must be at least 8");
      end
      if (REG_CNT != 16) begin : g_bad_reg_cnt
         $error("smcpu_core: the 4-bit register field needs REG_CNT of 16");
      end
   endgenerate

   // architectural and staging state
   logic [PC_W-1:0]    pc_q;
   logic [PC_W-1:0]    tgt_q;
   logic [INSTR_W-1:0] ir_q;
   logic [DATA_W-1:0]  a_q;
   logic [DATA_W-1:0]  b_q;
   logic [DATA_W-1:0]  res_q;

   phase_e             phase;
   decode_t            dec;
   logic               rf_we;
   logic               mem_we;
   logic               mem_cap;

   logic [DATA_W-1:0]  rd_a;
   logic [DATA_W-1:0]  rd_b;
   logic [DATA_W-1:0]  alu_y;
   logic [IDX_W-1:0]   rn_idx;
   logic [IDX_W-1:0]   rm_idx;
   logic [FIELD_W-1:0] arg;
   logic [PC_W-1:0]    off_ext;

   assign rn_idx  = ir_q[11:8];
   assign rm_idx  = ir_q[7:4];
   assign arg     = ir_q[7:0];
   assign off_ext = PC_W'($signed(arg));

   smcpu_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .opc     (ir_q[15:12]),
      .phase   (phase),
      .dec     (dec),
      .rf_we   (rf_we),
      .mem_we  (mem_we),
      .mem_cap (mem_cap)
   );

   smcpu_regfile #(
      .DATA_W  (DATA_W),
      .REG_CNT (REG_CNT)
   ) u_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (rf_we),
      .waddr   (rn_idx),
      .wdata   (res_q),
      .raddr_a (rn_idx),
      .rdata_a (rd_a),
      .raddr_b (rm_idx),
      .rdata_b (rd_b)
   );

   smcpu_alu #(
      .DATA_W      (DATA_W),
      .SUB_VIA_ADD (SUB_VIA_ADD)
   ) u_alu (
      .a   (a_q),
      .b   (b_q),
      .sub (dec.sub),
      .y   (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         tgt_q <= '0;
         ir_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         res_q <= '0;
      end else begin
         case (phase)
            PH_FETCH:  ir_q <= prog_data;
            PH_DECODE: begin
               a_q <= rd_a;
               b_q <= rd_b;
            end
            PH_EXEC: begin
               res_q <= dec.imm ? DATA_W'(arg) : alu_y;
               if (dec.branch && (a_q == '0))
                  tgt_q <= pc_q + off_ext;
               else
                  tgt_q <= pc_q + PC_W'(1);
            end
            PH_MEM: begin
               if (mem_cap)
                  res_q <= dmem_rdata;
            end
            default:   pc_q <= tgt_q;
         endcase
      end
   end

   assign prog_addr  = pc_q;
   assign dmem_addr  = dec.indirect ? a_q : DATA_W'(arg);
   assign dmem_wdata = dec.indirect ? b_q : a_q;
   assign dmem_we    = mem_we;
   assign dbg_pc     = pc_q;
   assign dbg_rf_we  = rf_we;

endmodule

// File: rtl/smcpu_core_chk.sv
module smcpu_core_chk #(
   parameter int PC_W   = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [PC_W-1:0]   dbg_pc,
   input logic              dbg_rf_we,
   input logic              dmem_we,
   input logic [DATA_W-1:0] dmem_addr,
   input logic [15:0]       ir
);

   // five-step counter kept independently of the controller
   logic [2:0] ph;
   always_ff @(posedge clk) begin
      if (rst)
         ph <= 3'd0;
      else
         ph <= (ph == 3'd4) ? 3'd0 : ph + 3'd1;
   end

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (dbg_pc == '0 && !dbg_rf_we && !dmem_we));

   a_r2_pc_held: assert property (@(posedge clk) disable iff (rst)
      (ph != 3'd4) |=> $stable(dbg_pc));

   a_r10_mem_write_step: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> (ph == 3'd3));

   a_r10_rf_write_step: assert property (@(posedge clk) disable iff (rst)
      dbg_rf_we |-> (ph == 3'd4));

   a_r9_unused_no_rf_write: assert property (@(posedge clk) disable iff (rst)
      (ph == 3'd4 && ir[15:12] > 4'h6) |-> !dbg_rf_we);

   a_r9_unused_steps_one: assert property (@(posedge clk) disable iff (rst)
      (ph == 3'd4 && ir[15:12] > 4'h6) |=> (dbg_pc == $past(dbg_pc) + PC_W'(1)));

   a_r4_direct_address: assert property (@(posedge clk) disable iff (rst)
      (dmem_we && ir[15:12] == 4'h1) |-> (dmem_addr == DATA_W'(ir[7:0])));

endmodule

bind smcpu_core smcpu_core_chk #(
   .PC_W   (PC_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .dbg_pc    (dbg_pc),
   .dbg_rf_we (dbg_rf_we),
   .dmem_we   (dmem_we),
   .dmem_addr (dmem_addr),
   .ir        (ir_q)
);

// File: tb/smcpu_core_bench.sv
module smcpu_core_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  prog_addr;
   logic [15:0] prog_data;
   logic [7:0]  dmem_addr;
   logic        dmem_we;
   logic [7:0]  dmem_wdata;
   logic [7:0]  dmem_rdata;
   logic [7:0]  dbg_pc;
   logic        dbg_rf_we;

   logic [15:0] prog [256];
   logic [7:0]  dmem [256];

   logic        poke_en = 1'b0;
   logic [7:0]  poke_addr = '0;
   logic [7:0]  poke_data = '0;
   logic        clr_cnt = 1'b0;
   int          wr_cnt;
   int          rf_cnt;

   int          checks = 0;
   int          errors = 0;
   logic        done = 1'b0;

   // vector: {subtract, a, b, expected}
   localparam logic [24:0] VECS [6] = '{
      {1'b0, 8'd3,   8'd4,   8'd7},
      {1'b0, 8'd200, 8'd100, 8'd44},
      {1'b0, 8'd255, 8'd1,   8'd0},
      {1'b1, 8'd10,  8'd3,   8'd7},
      {1'b1, 8'd0,   8'd0,   8'd0},
      {1'b1, 8'd3,   8'd10,  8'd249}
   };

   always #(CLK_P/2) clk = ~clk;

   smcpu_core u_smcpu_core (
      .clk        (clk),
      .rst        (rst),
      .prog_addr  (prog_addr),
      .prog_data  (prog_data),
      .dmem_addr  (dmem_addr),
      .dmem_we    (dmem_we),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata),
      .dbg_pc     (dbg_pc),
      .dbg_rf_we  (dbg_rf_we)
   );

   assign prog_data  = prog[prog_addr];
   assign dmem_rdata = dmem[dmem_addr];

   always @(posedge clk) begin
      if (poke_en)
         dmem[poke_addr] <= poke_data;
      else if (dmem_we)
         dmem[dmem_addr] <= dmem_wdata;
      if (clr_cnt) begin
         wr_cnt <= 0;
         rf_cnt <= 0;
      end else begin
         if (dmem_we)   wr_cnt <= wr_cnt + 1;
         if (dbg_rf_we) rf_cnt <= rf_cnt + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic poke(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      poke_en = 1'b1; poke_addr = a; poke_data = d;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 256; i++) prog[i] = 16'hF000;
   endtask

   task automatic enter_reset();
      @(negedge clk);
      rst = 1'b1;
      clr_cnt = 1'b1;
      run(2);
      clr_cnt = 1'b0;
   endtask

   task automatic leave_reset();
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      // ---- table walk: R6, R7 through load-immediate, add, sub, store
      clear_prog();
      for (int i = 0; i < 6; i++) begin
         prog[4*i]   = {4'h3, 4'h1, VECS[i][23:16]};
         prog[4*i+1] = {4'h3, 4'h2, VECS[i][15:8]};
         prog[4*i+2] = {(VECS[i][24] ? 4'h5 : 4'h4), 4'h1, 8'h20};
         prog[4*i+3] = {4'h1, 4'h1, 8'(8'h40 + i)};
      end
      prog[24] = 16'h6000;
      clr_cnt = 1'b1;
      run(3);
      clr_cnt = 1'b0;
      check("R1 pc in reset", 32'(dbg_pc), 0);
      check("R1 mem write in reset", 32'(dmem_we), 0);
      check("R1 rf write in reset", 32'(dbg_rf_we), 0);
      leave_reset();
      run(130);
      for (int i = 0; i < 6; i++)
         check("R7 add/sub vector", 32'(dmem[64+i]), 32'(VECS[i][7:0]));
      check("R4 store count", 32'(wr_cnt), 6);
      check("R6 rf write count", 32'(rf_cnt), 18);
      check("R8 halt reached", 32'(dbg_pc), 24);

      // ---- directed: reset clears, load/store, indirect, unused opcodes
      enter_reset();
      check("R1 pc cleared by reset", 32'(dbg_pc), 0);
      clear_prog();
      prog[0]  = 16'h1110;   // ST R1,0x10 (R1 held 249 before reset)
      prog[1]  = 16'h0320;   // LD R3,0x20
      prog[2]  = 16'h1321;   // ST R3,0x21
      prog[3]  = 16'h3430;   // LDI R4,0x30
      prog[4]  = 16'h3677;   // LDI R6,0x77
      prog[5]  = 16'h246F;   // STI R4,R6 with low nibble 0xF
      prog[6]  = 16'h3711;   // LDI R7,0x11
      prog[7]  = 16'h77FF;   // unused opcode 7
      prog[8]  = 16'hF7FF;   // unused opcode F
      prog[9]  = 16'h1731;   // ST R7,0x31
      prog[10] = 16'h6000;   // halt
      poke(8'h10, 8'hAA);
      poke(8'h20, 8'h5A);
      poke(8'h21, 8'h00);
      poke(8'h30, 8'h00);
      poke(8'h31, 8'h00);
      poke(8'hFF, 8'hC3);
      leave_reset();
      run(80);
      check("R1 registers cleared", 32'(dmem[8'h10]), 0);
      check("R3 load direct", 32'(dmem[8'h21]), 32'h5A);
      check("R5 store indirect", 32'(dmem[8'h30]), 32'h77);
      check("R11 Rm from bits 7:4", 32'(dmem[8'h30]), 32'h77);
      check("R9 register kept across unused", 32'(dmem[8'h31]), 32'h11);
      check("R9 no stray write", 32'(dmem[8'hFF]), 32'hC3);
      check("R9 rf write count", 32'(rf_cnt), 4);
      check("R4 store count", 32'(wr_cnt), 4);
      check("R9 pc past unused", 32'(dbg_pc), 10);

      // ---- directed: branches and a counting loop
      enter_reset();
      clear_prog();
      prog[0]  = 16'h3000;   // LDI R0,0
      prog[1]  = 16'h3105;   // LDI R1,5
      prog[2]  = 16'h6103;   // JZ R1,+3 not taken
      prog[3]  = 16'h6003;   // JZ R0,+3 taken -> 6
      prog[4]  = 16'h3299;
      prog[5]  = 16'h3299;
      prog[6]  = 16'h3242;   // LDI R2,0x42
      prog[7]  = 16'h1250;   // ST R2,0x50
      prog[8]  = 16'h3500;   // LDI R5,0
      prog[9]  = 16'h360A;   // LDI R6,10
      prog[10] = 16'h3701;   // LDI R7,1
      prog[11] = 16'h6604;   // JZ R6,+4 -> 15
      prog[12] = 16'h4560;   // ADD R5,R6
      prog[13] = 16'h5670;   // SUB R6,R7
      prog[14] = 16'h60FD;   // JZ R0,-3 -> 11
      prog[15] = 16'h1560;   // ST R5,0x60
      prog[16] = 16'h6000;   // halt
      poke(8'h50, 8'h00);
      poke(8'h60, 8'h00);
      leave_reset();
      run(4);
      check("R2 pc held for four cycles", 32'(dbg_pc), 0);
      run(1);
      check("R2 pc after fifth cycle", 32'(dbg_pc), 1);
      run(5);
      check("R2 pc second instruction", 32'(dbg_pc), 2);
      run(5);
      check("R8 branch not taken", 32'(dbg_pc), 3);
      run(5);
      check("R8 branch taken forward", 32'(dbg_pc), 6);
      run(5);
      check("R8 next after target", 32'(dbg_pc), 7);
      run(400);
      check("R8 skipped code", 32'(dmem[8'h50]), 32'h42);
      check("R8 backward loop sum", 32'(dmem[8'h60]), 55);
      check("R8 loop exit pc", 32'(dbg_pc), 16);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule